// File: doc/BRIEF.md
# Interrupt and Halt Sequencer

This block sits beside the instruction sequencer of an 8-bit processor core. At each instruction boundary it chooses one of four outcomes: a restart caused by a reset request, a non-maskable interrupt, a maskable interrupt, or an ordinary opcode fetch. It holds the two interrupt enable flip-flops (`iff1` as the live enable, `iff2` as the copy kept across a non-maskable service), the two-bit maskable response mode, the interrupt vector register and the halt flag.

The core pulses `boundary` once for each instruction it completes. It raises a single strobe for each of the interrupt control instructions it decodes: disable, enable, return-from-NMI, set-mode (with the opcode's 3-bit y field on `im_sel`), halt, and load of the vector register. The sequencer replies with a one-cycle `fetch_go` pulse or a one-cycle `resp_valid` pulse that carries the kind of restart and its target address. A maskable service runs a short bus sequence first. Pushing the program counter and executing the byte returned in mode 0 stay with the core. `resp_exec` tells the core to run that byte, and the byte appears in `resp_addr[7:0]`.

Top module: `irq_sequencer`

## Requirements
- R1: While `rst_n` is low, at each clock edge both enables, the mode, the vector register, the halt flag and all pulse outputs are cleared, and no NMI stays pending.
- R2: A boundary is resolved in priority order: reset request, then NMI, then maskable interrupt, then fetch. A taken reset request pulses `resp_valid` in the next cycle with `resp_kind`=0 and address 0x0000. It clears both enables, the mode, the vector register, the halt flag and any pending NMI.
- R3: A taken NMI pulses `resp_valid` in the next cycle with `resp_kind`=1 and address 0x0066. It copies `iff1` into `iff2`, clears `iff1` and clears the halt flag.
- R4: A rising edge on `nmi_req` is latched until it is serviced. One pulse, or one level held high over many boundaries, yields exactly one NMI service.
- R5: A maskable interrupt is taken only when `int_req` is high and `iff1` is 1. Taking it clears both enables and the halt flag. With `iff1` at 0 the boundary gives a normal fetch.
- R6: After a maskable interrupt is taken at boundary cycle B, `busy` is high from B+1. `ack_cycle` is high in B+3 only, and `ack_data` is captured in that cycle. `resp_valid` rises in B+4 for modes 0 and 1 and in B+11 for mode 2, and `busy` falls in that same cycle.
- R7: In a maskable response `resp_kind` is 2. Mode 0 sets `resp_exec` and gives address {0x00, byte}. Mode 1 gives 0x0038. Mode 2 gives {vector register, byte}.
- R8: The disable strobe clears both enables. The enable strobe sets both.
- R9: The return-from-NMI strobe copies `iff2` into `iff1`.
- R10: The set-mode strobe maps `im_sel` as follows: 0, 1, 4 and 5 give mode 0; 2 and 6 give mode 1; 3 and 7 give mode 2. `vec_load` writes `vec_data` into the vector register.
- R11: The halt strobe sets `halted`. The flag stays set across fetch boundaries and is cleared when any restart is taken.
- R12: A boundary that takes nothing pulses `fetch_go` in the next cycle. Instruction strobes act only in idle cycles without a boundary. While `busy` is high, boundaries and strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| boundary | input | 1 | Instruction boundary strobe |
| reset_req | input | 1 | Reset request level |
| nmi_req | input | 1 | Non-maskable request, active high, edge latched |
| int_req | input | 1 | Maskable request level |
| ack_data | input | 8 | Byte supplied by the device during the acknowledge cycle |
| op_di | input | 1 | Disable-interrupts strobe |
| op_ei | input | 1 | Enable-interrupts strobe |
| op_retn | input | 1 | Return-from-NMI strobe |
| op_im | input | 1 | Set-mode strobe |
| im_sel | input | 3 | y field of the set-mode opcode |
| op_halt | input | 1 | Halt strobe |
| vec_load | input | 1 | Vector register write strobe |
| vec_data | input | 8 | Vector register write data |
| iff1 | output | 1 | Live interrupt enable |
| iff2 | output | 1 | Saved interrupt enable |
| int_mode | output | 2 | Maskable response mode |
| vec_reg | output | 8 | Interrupt vector register |
| halted | output | 1 | Halt state; the core forces no-operation fetches |
| busy | output | 1 | Maskable acknowledge sequence in progress |
| fetch_go | output | 1 | One-cycle pulse: proceed with a normal fetch |
| ack_cycle | output | 1 | Acknowledge read cycle (I/O request plus opcode fetch) |
| resp_valid | output | 1 | One-cycle pulse: restart response valid |
| resp_kind | output | 2 | 0 reset, 1 NMI, 2 maskable |
| resp_exec | output | 1 | Mode 0: core executes the byte in resp_addr[7:0] |
| resp_addr | output | 16 | Restart or call target |

## Verification
Every result is due a fixed number of cycles after the boundary or strobe that causes it. Fetch, reset and NMI responses and all register updates appear one cycle later. The acknowledge cycle comes three cycles after a maskable acceptance, and the response four cycles after it, or eleven in mode 2. The bench drives stimulus on falling edges and steps exactly that many falling edges before it reads a directed check. A behavioural model keeps an elapsed-cycle counter for each sequence and is compared with every output on every falling edge, so a result that arrives a cycle early or late is caught in the cycle where it goes wrong.

// File: rtl/irq_sequencer.sv
module irq_sequencer #(
  parameter int SETTLE_CYC = 2,
  parameter int TABLE_CYC  = 7,
  parameter logic [15:0] NMI_ADDR  = 16'h0066,
  parameter logic [15:0] MODE1_ADDR = 16'h0038
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        boundary,
  input  logic        reset_req,
  input  logic        nmi_req,
  input  logic        int_req,
  input  logic [7:0]  ack_data,
  input  logic        op_di,
  input  logic        op_ei,
  input  logic        op_retn,
  input  logic        op_im,
  input  logic [2:0]  im_sel,
  input  logic        op_halt,
  input  logic        vec_load,
  input  logic [7:0]  vec_data,
  output logic        iff1,
  output logic        iff2,
  output logic [1:0]  int_mode,
  output logic [7:0]  vec_reg,
  output logic        halted,
  output logic        busy,
  output logic        fetch_go,
  output logic        ack_cycle,
  output logic        resp_valid,
  output logic [1:0]  resp_kind,
  output logic        resp_exec,
  output logic [15:0] resp_addr
);
  localparam int MAXC = (SETTLE_CYC > TABLE_CYC) ? SETTLE_CYC : TABLE_CYC;
  localparam int CW = (MAXC > 1) ? $clog2(MAXC) : 1;

  typedef enum logic [1:0] {S_IDLE, S_SETTLE, S_ACK, S_TABLE} st_t;
  st_t st;
  logic [CW-1:0] cnt;
  logic          nmi_q, nmi_pend;
  logic [7:0]    ack_q;

  wire idle      = (st == S_IDLE);
  wire nmi_edge  = nmi_req & ~nmi_q;
  wire nmi_hit   = nmi_pend | nmi_edge;
  wire take_rst  = idle & boundary & reset_req;
  wire take_nmi  = idle & boundary & ~reset_req & nmi_hit;
  wire take_int  = idle & boundary & ~reset_req & ~nmi_hit & int_req & iff1;
  wire strobe_ok = idle & ~boundary;
  wire [1:0] im_dec = im_sel[1] ? (im_sel[0] ? 2'd2 : 2'd1) : 2'd0;

  assign busy      = ~idle;
  assign ack_cycle = (st == S_ACK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      nmi_q <= 1'b0;
      nmi_pend <= 1'b0;
      ack_q <= '0;
      iff1 <= 1'b0;
      iff2 <= 1'b0;
      int_mode <= 2'd0;
      vec_reg <= '0;
      halted <= 1'b0;
      fetch_go <= 1'b0;
      resp_valid <= 1'b0;
      resp_kind <= 2'd0;
      resp_exec <= 1'b0;
      resp_addr <= '0;
    end else begin
      nmi_q <= nmi_req;
      nmi_pend <= (nmi_pend | nmi_edge) & ~take_nmi & ~take_rst;
      fetch_go <= idle & boundary & ~take_rst & ~take_nmi & ~take_int;
      resp_valid <= 1'b0;
      resp_exec <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (take_rst) begin
            iff1 <= 1'b0;
            iff2 <= 1'b0;
            int_mode <= 2'd0;
            vec_reg <= '0;
            halted <= 1'b0;
            resp_valid <= 1'b1;
            resp_kind <= 2'd0;
            resp_addr <= 16'h0000;
          end else if (take_nmi) begin
            iff2 <= iff1;
            iff1 <= 1'b0;
            halted <= 1'b0;
            resp_valid <= 1'b1;
            resp_kind <= 2'd1;
            resp_addr <= NMI_ADDR;
          end else if (take_int) begin
            iff1 <= 1'b0;
            iff2 <= 1'b0;
            halted <= 1'b0;
            st <= S_SETTLE;
            cnt <= CW'(SETTLE_CYC - 1);
          end else if (strobe_ok) begin
            if (op_di) begin
              iff1 <= 1'b0;
              iff2 <= 1'b0;
            end
            if (op_ei) begin
              iff1 <= 1'b1;
              iff2 <= 1'b1;
            end
            if (op_retn) iff1 <= iff2;
            if (op_im) int_mode <= im_dec;
            if (op_halt) halted <= 1'b1;
            if (vec_load) vec_reg <= vec_data;
          end
        end
        S_SETTLE: begin
          if (cnt == '0) st <= S_ACK;
          else cnt <= cnt - 1'b1;
        end
        S_ACK: begin
          if (int_mode == 2'd2) begin
            ack_q <= ack_data;
            st <= S_TABLE;
            cnt <= CW'(TABLE_CYC - 1);
          end else begin
            resp_valid <= 1'b1;
            resp_kind <= 2'd2;
            resp_exec <= (int_mode == 2'd0);
            resp_addr <= (int_mode == 2'd1) ? MODE1_ADDR : {8'h00, ack_data};
            st <= S_IDLE;
          end
        end
        S_TABLE: begin
          if (cnt == '0) begin
            resp_valid <= 1'b1;
            resp_kind <= 2'd2;
            resp_addr <= {vec_reg, ack_q};
            st <= S_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({resp_valid, fetch_go, ack_cycle})); // R12
  AST_NMI_DROPS_IFF1: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_kind == 2'd1) |-> !iff1); // R3
  AST_ACK_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    ack_cycle |-> (!iff1 && !iff2)); // R5
  AST_DI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_ok && op_di && !op_ei) |=> (!iff1 && !iff2)); // R8
  AST_EI_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_ok && op_ei) |=> (iff1 && iff2)); // R8
  AST_RETN_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_ok && op_retn && !op_di && !op_ei) |=> (iff1 == $past(iff2))); // R9
  AST_RESP_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !halted); // R11
  AST_BUSY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(int_mode) && $stable(vec_reg))); // R12
endmodule

// File: tb/irq_sequencer_test.sv
module irq_sequencer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic boundary = 0, reset_req = 0, nmi_req = 0, int_req = 0;
  logic [7:0] ack_data = 8'h00;
  logic op_di = 0, op_ei = 0, op_retn = 0, op_im = 0, op_halt = 0, vec_load = 0;
  logic [2:0] im_sel = 3'd0;
  logic [7:0] vec_data = 8'h00;
  logic iff1, iff2, halted, busy, fetch_go, ack_cycle, resp_valid, resp_exec;
  logic [1:0] int_mode, resp_kind;
  logic [7:0] vec_reg;
  logic [15:0] resp_addr;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_sequencer uut (
    .clk(clk), .rst_n(rst_n), .boundary(boundary), .reset_req(reset_req),
    .nmi_req(nmi_req), .int_req(int_req), .ack_data(ack_data),
    .op_di(op_di), .op_ei(op_ei), .op_retn(op_retn), .op_im(op_im),
    .im_sel(im_sel), .op_halt(op_halt), .vec_load(vec_load), .vec_data(vec_data),
    .iff1(iff1), .iff2(iff2), .int_mode(int_mode), .vec_reg(vec_reg),
    .halted(halted), .busy(busy), .fetch_go(fetch_go), .ack_cycle(ack_cycle),
    .resp_valid(resp_valid), .resp_kind(resp_kind), .resp_exec(resp_exec),
    .resp_addr(resp_addr));

  // behavioural reference: elapsed-cycle counter for the maskable sequence
  bit m_i1, m_i2, m_halt, m_act, m_fetch, m_ack, m_resp, m_exec, m_pend, m_nprev;
  int m_mode, m_vec, m_k, m_due, m_byte, m_kind, m_addr;
  bit m_seen = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_i1 = 0; m_i2 = 0; m_halt = 0; m_act = 0; m_fetch = 0; m_ack = 0;
      m_resp = 0; m_exec = 0; m_pend = 0; m_nprev = 0; m_mode = 0; m_vec = 0;
      m_k = 0; m_byte = 0; m_kind = 0; m_addr = 0; m_seen = 1;
    end else begin
      bit edge_now;
      edge_now = nmi_req && !m_nprev;
      m_nprev = nmi_req;
      m_fetch = 0; m_resp = 0; m_exec = 0;
      if (m_act) begin
        if (m_k == 3) m_byte = ack_data;
        m_k++;
        if (m_k == m_due) begin
          m_act = 0; m_resp = 1; m_kind = 2;
          if (m_mode == 2) m_addr = m_vec * 256 + m_byte;
          else if (m_mode == 1) m_addr = 16'h0038;
          else begin m_addr = m_byte; m_exec = 1; end
        end
      end else if (boundary) begin
        if (reset_req) begin
          m_i1 = 0; m_i2 = 0; m_mode = 0; m_vec = 0; m_halt = 0;
          m_pend = 0; edge_now = 0; m_resp = 1; m_kind = 0; m_addr = 0;
        end else if (m_pend || edge_now) begin
          m_pend = 0; edge_now = 0; m_i2 = m_i1; m_i1 = 0; m_halt = 0;
          m_resp = 1; m_kind = 1; m_addr = 16'h0066;
        end else if (int_req && m_i1) begin
          m_i1 = 0; m_i2 = 0; m_halt = 0; m_act = 1; m_k = 1;
          m_due = (m_mode == 2) ? 11 : 4;
        end else m_fetch = 1;
      end else begin
        if (op_di) begin m_i1 = 0; m_i2 = 0; end
        if (op_ei) begin m_i1 = 1; m_i2 = 1; end
        if (op_retn) m_i1 = m_i2;
        if (op_im) case (im_sel)
          3'd0, 3'd1, 3'd4, 3'd5: m_mode = 0;
          3'd2, 3'd6: m_mode = 1;
          default: m_mode = 2;
        endcase
        if (op_halt) m_halt = 1;
        if (vec_load) m_vec = vec_data;
      end
      m_pend = m_pend | edge_now;
      m_ack = m_act && (m_k == 3);
    end
  end

  task automatic cmp(string tag, string nm, int got, int exp, inout bit bad);
    if (got != exp) begin
      $display("FAIL %s cycle %0d %s actual %0h expected %0h", tag, cyc, nm, got, exp);
      bad = 1;
    end
  endtask

  always @(negedge clk) begin
    if (m_seen && !done) begin
      bit bad = 0;
      checks++;
      cmp("R5", "iff1", iff1, m_i1, bad);
      cmp("R9", "iff2", iff2, m_i2, bad);
      cmp("R10", "int_mode", int_mode, m_mode, bad);
      cmp("R2", "vec_reg", vec_reg, m_vec, bad);
      cmp("R11", "halted", halted, m_halt, bad);
      cmp("R6", "busy", busy, m_act, bad);
      cmp("R12", "fetch_go", fetch_go, m_fetch, bad);
      cmp("R6", "ack_cycle", ack_cycle, m_ack, bad);
      cmp("R6", "resp_valid", resp_valid, m_resp, bad);
      cmp("R7", "resp_exec", resp_exec, m_exec, bad);
      cmp("R7", "resp_kind", resp_kind, m_kind, bad);
      cmp("R7", "resp_addr", resp_addr, m_addr, bad);
      if (bad) fails++;
    end
  end

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s directed: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bnd();
    boundary = 1; step(1); boundary = 0;
  endtask

  task automatic ei(); op_ei = 1; step(1); op_ei = 0; endtask
  task automatic di(); op_di = 1; step(1); op_di = 0; endtask
  task automatic setim(int y); op_im = 1; im_sel = 3'(y); step(1); op_im = 0; endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    step(3);
    chk("R1", {iff1, iff2, halted, fetch_go, resp_valid, ack_cycle, busy}, 0);
    chk("R1", {int_mode, vec_reg}, 0);
    rst_n = 1;
    step(1);
    bnd();
    chk("R12", fetch_go, 1);
    chk("R12", resp_valid, 0);

    vec_load = 1; vec_data = 8'h5A; step(1); vec_load = 0;
    chk("R10", vec_reg, 8'h5A);
    ei();
    chk("R8", {iff1, iff2}, 2'b11);
    di();
    chk("R8", {iff1, iff2}, 2'b00);

    for (int y = 0; y < 8; y++) begin
      int e;
      setim(y);
      case (y)
        0, 1, 4, 5: e = 0;
        2, 6: e = 1;
        default: e = 2;
      endcase
      chk("R10", int_mode, e);
    end

    // mode 1 from halt
    setim(2); ei();
    op_halt = 1; step(1); op_halt = 0;
    chk("R11", halted, 1);
    bnd();
    chk("R11", {halted, fetch_go}, 2'b11);
    int_req = 1; bnd(); int_req = 0;
    chk("R5", {busy, iff1, iff2, halted}, 4'b1000);
    step(2);
    chk("R6", ack_cycle, 1);
    step(1);
    chk("R6", {resp_valid, busy}, 2'b10);
    chk("R7", resp_kind, 2);
    chk("R7", resp_addr, 16'h0038);
    chk("R7", resp_exec, 0);

    // mode 2, enable strobe during busy must be ignored
    setim(3); ei(); ack_data = 8'h34;
    int_req = 1; bnd(); int_req = 0;
    step(2);
    chk("R6", ack_cycle, 1);
    step(1);
    chk("R6", resp_valid, 0);
    op_ei = 1; step(1); op_ei = 0;
    step(5);
    chk("R6", {resp_valid, busy}, 2'b01);
    step(1);
    chk("R6", {resp_valid, busy}, 2'b10);
    chk("R7", resp_addr, 16'h5A34);
    chk("R12", {iff1, iff2}, 2'b00);

    // mode 0
    setim(0); ei(); ack_data = 8'hFF;
    int_req = 1; bnd(); int_req = 0;
    step(3);
    chk("R7", {resp_valid, resp_exec}, 2'b11);
    chk("R7", resp_addr, 16'h00FF);

    // masked
    di(); int_req = 1; bnd();
    chk("R5", {fetch_go, busy}, 2'b10);
    step(3);
    chk("R5", resp_valid, 0);
    int_req = 0;

    // NMI pulse latched between boundaries
    ei();
    nmi_req = 1; step(1); nmi_req = 0; step(2);
    bnd();
    chk("R3", {resp_valid, resp_kind}, 3'b101);
    chk("R3", resp_addr, 16'h0066);
    chk("R3", {iff1, iff2}, 2'b01);
    bnd();
    chk("R4", {fetch_go, resp_valid}, 2'b10);
    op_retn = 1; step(1); op_retn = 0;
    chk("R9", iff1, 1);

    // held level gives one service
    nmi_req = 1; bnd();
    chk("R4", resp_valid, 1);
    bnd();
    chk("R4", fetch_go, 1);
    bnd();
    chk("R4", fetch_go, 1);
    nmi_req = 0; step(1);

    // NMI wakes from halt
    op_halt = 1; step(1); op_halt = 0;
    nmi_req = 1; bnd(); nmi_req = 0;
    chk("R11", {resp_valid, halted}, 2'b10);

    // priority
    vec_load = 1; vec_data = 8'h77; step(1); vec_load = 0;
    setim(7); ei();
    reset_req = 1; nmi_req = 1; int_req = 1; bnd(); reset_req = 0;
    chk("R2", {resp_valid, resp_kind}, 3'b100);
    chk("R2", resp_addr, 0);
    chk("R2", {iff1, iff2, int_mode, vec_reg}, 0);
    bnd();
    chk("R2", fetch_go, 1);
    nmi_req = 0; step(1); ei();
    nmi_req = 1; bnd(); nmi_req = 0; int_req = 0;
    chk("R2", {resp_valid, resp_kind}, 3'b101);
    step(4);
    finish_run();
  end
endmodule